// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. Each pulse on its one-per-second tick input advances the seconds. The seconds carry into the minutes, the minutes into the hours, and the hours into the date and the day of week. Past the last day of a month the date returns to 01 and the month advances. The year follows the month, and a century flag toggles when the year wraps.

Hours run in either 24-hour or 12-hour form, and the form is chosen by a bit stored in the hours byte itself. A host can set any field through a parallel load port: a write strobe, a field selector and a data byte. Every field is presented on its own registered output at all times. A seven-bit wrap strobe marks, field by field, the cycle in which a field rolls over.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hours 00 in 24-hour form, day of week 01, date 01, month 01 with century bit 0, year 00, and all wrap strobes low.
- R2: Seconds and minutes count 00 to 59 in BCD. One step of a field happens only when every lower field wraps on the same tick, and 59 is followed by 00.
- R3: With hours bit 6 at 0 (24-hour form), bits 5:0 hold BCD hours 00 to 23. 23 is followed by 00, and that step is midnight.
- R4: With hours bit 6 at 1 (12-hour form), bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD hours 1 to 12. 12 is followed by 01 with the flag kept. 11 is followed by 12 with the flag inverted, and the step from 11 PM is midnight.
- R5: Day of week counts 1 to 7, advances only at midnight, and 7 is followed by 1.
- R6: The last date of a month is 31, or 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the two-digit year is a multiple of 4 and 28 otherwise. At midnight on the last date the date becomes 01 and the month advances.
- R7: Month 12 is followed by 01, and that step advances the year. Year 99 is followed by 00, and that step inverts the century flag at month bit 7. The flag changes at no other step.
- R8: A load writes the data byte into the selected field at the next clock edge. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month (bit 7 loads the century flag), 6 year; code 7 writes nothing. A tick in the load cycle is discarded for all fields, and counting resumes from the loaded value on the next tick.
- R9: Wrap bit order is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Each bit is high for exactly the one cycle in which its field's wrapped value first appears on the outputs.
- R10: With no tick and no load, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per second |
| ld_we_i | input | 1 | Load strobe |
| ld_sel_i | input | 3 | Field selector for the load |
| ld_data_i | input | 8 | BCD byte to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with mode bit 6 and bit 5 |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month in bits 4:0, century flag in bit 7 |
| year_o | output | 8 | Year, BCD |
| wrap_o | output | 7 | Per-field rollover strobes |

## Verification
The bench loads fields just short of each boundary and then ticks across it. The boundaries are 59 to 00, midnight in both hour forms, the 11 to 12 flip of the PM flag, 12 to 01 keeping the flag, February in leap and common years, 30-day and 31-day months, and the year and century wrap. A design that treated 12 as midnight, toggled PM at the wrong hour, or stepped the day of week at noon would show a wrong hour or day right after the crossing. A wrong leap test or month table would land on a date of 29 or 31 where 01 is due. The bench also ticks in the same cycle as a load and expects the loaded value to stand unchanged, and it checks that each wrap strobe lasts exactly one cycle.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;
  localparam int BYTE_W = 8;
  localparam int NFIELD = 7;
  localparam int SEL_W  = 3;

  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mon,
                                                 input logic [BYTE_W-1:0] yr);
    logic [BYTE_W-1:0] ybin;
    ybin = {4'd0, yr[7:4]} * 8'd10 + {4'd0, yr[3:0]};
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_ring.sv
module bcd_ring
  import clk_cal_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LOW   = 8'h00,
  parameter logic [BYTE_W-1:0] RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_val_i,
  input  logic [BYTE_W-1:0] top_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              carry_o
);
  assign carry_o = inc_i && !ld_i && (q_o == top_i);

  always_ff @(posedge clk) begin
    if (rst)        q_o <= RESET;
    else if (ld_i)  q_o <= ld_val_i;
    else if (inc_i) q_o <= (q_o == top_i) ? LOW : bcd_inc(q_o);
  end
endmodule

// File: rtl/hour_cnt.sv
module hour_cnt
  import clk_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] ld_val_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              carry_o
);
  logic              mode12, pm;
  logic [BYTE_W-1:0] h12, h24, nxt12, nxt24, inc12, inc24;

  assign mode12 = q_o[6];
  assign pm     = q_o[5];
  assign h12    = {3'd0, q_o[4:0]};
  assign h24    = {2'd0, q_o[5:0]};
  assign inc12  = bcd_inc(h12);
  assign inc24  = bcd_inc(h24);

  always_comb begin
    if (h12 == 8'h12)      nxt12 = {2'b01, pm, 5'h01};
    else if (h12 == 8'h11) nxt12 = {2'b01, ~pm, 5'h12};
    else                   nxt12 = {2'b01, pm, inc12[4:0]};
    nxt24 = (h24 == 8'h23) ? 8'h00 : {2'b00, inc24[5:0]};
  end

  assign carry_o = inc_i && !ld_i &&
                   (mode12 ? (pm && h12 == 8'h11) : (h24 == 8'h23));

  always_ff @(posedge clk) begin
    if (rst)        q_o <= 8'h00;
    else if (ld_i)  q_o <= ld_val_i;
    else if (inc_i) q_o <= mode12 ? nxt12 : nxt24;
  end

  // R3
  h24_midnight_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && q_o == 8'h23) |=> q_o == 8'h00);
  // R4
  pm_midnight_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && q_o == 8'h71) |=> q_o == 8'h52);
  // R4
  noon_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && q_o == 8'h51) |=> q_o == 8'h72);
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import clk_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ld_we_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [BYTE_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] dow_o,
  output logic [BYTE_W-1:0] date_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o,
  output logic [NFIELD-1:0] wrap_o
);
  localparam int F_SEC = 0, F_MIN = 1, F_HR = 2, F_DOW = 3,
                 F_DATE = 4, F_MON = 5, F_YR = 6;

  logic [NFIELD-1:0] ld_hit;
  logic              step;
  logic              sec_c, min_c, hr_c, dow_c, date_c, mon_c, yr_c;
  logic [BYTE_W-1:0] mon_q, date_top;
  logic              century;

  for (genvar k = 0; k < NFIELD; k++) begin : g_hit
    assign ld_hit[k] = ld_we_i && (ld_sel_i == SEL_W'(k));
  end

  assign step     = tick_i && !ld_we_i;
  assign date_top = last_day(mon_q, year_o);

  bcd_ring #(.LOW(8'h00), .RESET(8'h00)) u_sec (
    .clk(clk), .rst(rst), .inc_i(step), .ld_i(ld_hit[F_SEC]),
    .ld_val_i(ld_data_i), .top_i(8'h59), .q_o(sec_o), .carry_o(sec_c));

  bcd_ring #(.LOW(8'h00), .RESET(8'h00)) u_min (
    .clk(clk), .rst(rst), .inc_i(sec_c), .ld_i(ld_hit[F_MIN]),
    .ld_val_i(ld_data_i), .top_i(8'h59), .q_o(min_o), .carry_o(min_c));

  hour_cnt u_hour (
    .clk(clk), .rst(rst), .inc_i(min_c), .ld_i(ld_hit[F_HR]),
    .ld_val_i(ld_data_i), .q_o(hour_o), .carry_o(hr_c));

  bcd_ring #(.LOW(8'h01), .RESET(8'h01)) u_dow (
    .clk(clk), .rst(rst), .inc_i(hr_c), .ld_i(ld_hit[F_DOW]),
    .ld_val_i(ld_data_i), .top_i(8'h07), .q_o(dow_o), .carry_o(dow_c));

  bcd_ring #(.LOW(8'h01), .RESET(8'h01)) u_date (
    .clk(clk), .rst(rst), .inc_i(hr_c), .ld_i(ld_hit[F_DATE]),
    .ld_val_i(ld_data_i), .top_i(date_top), .q_o(date_o), .carry_o(date_c));

  bcd_ring #(.LOW(8'h01), .RESET(8'h01)) u_mon (
    .clk(clk), .rst(rst), .inc_i(date_c), .ld_i(ld_hit[F_MON]),
    .ld_val_i({3'd0, ld_data_i[4:0]}), .top_i(8'h12), .q_o(mon_q), .carry_o(mon_c));

  bcd_ring #(.LOW(8'h00), .RESET(8'h00)) u_yr (
    .clk(clk), .rst(rst), .inc_i(mon_c), .ld_i(ld_hit[F_YR]),
    .ld_val_i(ld_data_i), .top_i(8'h99), .q_o(year_o), .carry_o(yr_c));

  always_ff @(posedge clk) begin
    if (rst)                century <= 1'b0;
    else if (ld_hit[F_MON]) century <= ld_data_i[7];
    else if (yr_c)          century <= ~century;
  end

  assign month_o = {century, 2'b00, mon_q[4:0]};

  always_ff @(posedge clk) begin
    if (rst) wrap_o <= '0;
    else     wrap_o <= {yr_c, mon_c, date_c, dow_c, hr_c, min_c, sec_c};
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !ld_we_i && sec_o == 8'h59) |=> sec_o == 8'h00);
  // R5
  dow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_we_i && !hr_c) |=> $stable(dow_o));
  // R7
  century_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_we_i && !yr_c) |=> $stable(month_o[7]));
  // R8
  sec_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_we_i && ld_sel_i == 3'd0) |=> sec_o == $past(ld_data_i));
  // R9
  wrap_sec_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o[0] |-> sec_o == 8'h00);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !ld_we_i) |=> ($stable(sec_o) && $stable(hour_o) && $stable(date_o)
                               && $stable(month_o) && $stable(year_o)));
endmodule

// File: tb/tb_bcd_clock_calendar.sv
module tb_bcd_clock_calendar;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       ld_we_i = 1'b0;
  logic [2:0] ld_sel_i = 3'd0;
  logic [7:0] ld_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic [6:0] wrap_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_clock_calendar dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ld_we_i(ld_we_i),
    .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .wrap_o(wrap_o));

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    ld_we_i = 1'b1; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, w, d, mo, y);
    load(3'd0, s); load(3'd1, m); load(3'd2, h); load(3'd3, w);
    load(3'd4, d); load(3'd5, mo); load(3'd6, y);
  endtask

  task automatic t_reset();
    chk("R1", "sec", sec_o, 8'h00);   chk("R1", "min", min_o, 8'h00);
    chk("R1", "hour", hour_o, 8'h00); chk("R1", "dow", dow_o, 8'h01);
    chk("R1", "date", date_o, 8'h01); chk("R1", "month", month_o, 8'h01);
    chk("R1", "year", year_o, 8'h00); chk("R1", "wrap", {1'b0, wrap_o}, 8'h00);
  endtask

  task automatic t_seconds();
    set_all(8'h58, 8'h09, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
    tick1(); chk("R2", "sec 58->59", sec_o, 8'h59);
    chk("R2", "min held", min_o, 8'h09);
    tick1(); chk("R2", "sec 59->00", sec_o, 8'h00);
    chk("R2", "min 09->10", min_o, 8'h10);
    chk("R9", "sec wrap strobe", {1'b0, wrap_o}, 8'h01);
    @(negedge clk); chk("R9", "strobe one cycle", {1'b0, wrap_o}, 8'h00);
    load(3'd1, 8'h59); load(3'd0, 8'h59);
    tick1(); chk("R2", "min 59->00", min_o, 8'h00);
    chk("R2", "hour 05->06", hour_o, 8'h06);
    chk("R9", "sec+min strobes", {1'b0, wrap_o}, 8'h03);
  endtask

  task automatic t_h24();
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h21);
    tick1();
    chk("R3", "23->00", hour_o, 8'h00);
    chk("R5", "dow 7->1", dow_o, 8'h01);
    chk("R6", "date 15->16", date_o, 8'h16);
    chk("R9", "midnight strobes", {1'b0, wrap_o}, 8'h0F);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'h11);
    tick1(); chk("R3", "11->12", hour_o, 8'h12);
    chk("R5", "dow not at noon", dow_o, 8'h01);
  endtask

  task automatic t_h12();
    set_all(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h06, 8'h21);
    tick1(); chk("R4", "11PM->12AM", hour_o, 8'h52);
    chk("R5", "dow at midnight", dow_o, 8'h04);
    chk("R6", "date at midnight", date_o, 8'h11);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'h51);
    tick1(); chk("R4", "11AM->12PM", hour_o, 8'h72);
    chk("R5", "dow held at noon", dow_o, 8'h04);
    chk("R6", "date held at noon", date_o, 8'h11);
    load(3'd0, 8'h59); load(3'd1, 8'h59);
    tick1(); chk("R4", "12PM->1PM", hour_o, 8'h61);
    load(3'd0, 8'h59); load(3'd1, 8'h59); load(3'd2, 8'h49);
    tick1(); chk("R4", "9AM->10AM", hour_o, 8'h50);
  endtask

  task automatic t_month(input logic [7:0] mo, y, d,
                         input logic [7:0] exp_d, exp_m, input string what);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, d, mo, y);
    tick1();
    chk("R6", {what, " date"}, date_o, exp_d);
    chk("R6", {what, " month"}, month_o, exp_m);
  endtask

  task automatic t_year();
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    tick1();
    chk("R7", "month 12->01 century set", month_o, 8'h81);
    chk("R7", "year 99->00", year_o, 8'h00);
    chk("R9", "all but dow strobes", {1'b0, wrap_o}, 8'h77);
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h45);
    tick1();
    chk("R7", "century held", month_o, 8'h01);
    chk("R7", "year 45->46", year_o, 8'h46);
    load(3'd5, 8'h85);
    chk("R8", "century loaded", month_o, 8'h85);
  endtask

  task automatic t_load();
    set_all(8'h10, 8'h20, 8'h08, 8'h02, 8'h05, 8'h05, 8'h30);
    @(negedge clk);
    ld_we_i = 1'b1; ld_sel_i = 3'd0; ld_data_i = 8'h30; tick_i = 1'b1;
    @(negedge clk);
    ld_we_i = 1'b0; tick_i = 1'b0;
    chk("R8", "load beats tick", sec_o, 8'h30);
    chk("R8", "min untouched", min_o, 8'h20);
    tick1(); chk("R8", "resume from load", sec_o, 8'h31);
    @(negedge clk);
    ld_we_i = 1'b1; ld_sel_i = 3'd2; ld_data_i = 8'h17; tick_i = 1'b1;
    @(negedge clk);
    ld_we_i = 1'b0; tick_i = 1'b0;
    chk("R8", "tick dropped on hour load", sec_o, 8'h31);
    chk("R8", "hour loaded", hour_o, 8'h17);
    load(3'd7, 8'h44);
    chk("R8", "code 7 sec", sec_o, 8'h31);  chk("R8", "code 7 min", min_o, 8'h20);
    chk("R8", "code 7 hour", hour_o, 8'h17); chk("R8", "code 7 dow", dow_o, 8'h02);
    chk("R8", "code 7 date", date_o, 8'h05); chk("R8", "code 7 month", month_o, 8'h05);
    chk("R8", "code 7 year", year_o, 8'h30);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R10", "sec idle", sec_o, 8'h31);
    chk("R10", "hour idle", hour_o, 8'h17);
    chk("R10", "date idle", date_o, 8'h05);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_seconds();
    t_h24();
    t_h12();
    t_month(8'h02, 8'h24, 8'h28, 8'h29, 8'h02, "leap feb 28");
    t_month(8'h02, 8'h24, 8'h29, 8'h01, 8'h03, "leap feb 29");
    t_month(8'h02, 8'h23, 8'h28, 8'h01, 8'h03, "common feb 28");
    t_month(8'h04, 8'h23, 8'h30, 8'h01, 8'h05, "april 30");
    t_month(8'h11, 8'h23, 8'h30, 8'h01, 8'h12, "november 30");
    t_month(8'h01, 8'h23, 8'h30, 8'h31, 8'h01, "january 30");
    t_month(8'h01, 8'h23, 8'h31, 8'h01, 8'h02, "january 31");
    t_year();
    t_load();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule